// File: doc/BRIEF.md
# Configurable UART Transmitter

The block turns one character, written into a one-deep holding buffer, into an asynchronous serial frame on a single output line. A frame opens with a low start bit, carries 7, 8 or 9 data bits, may add an odd or even parity bit, and closes with one or two high stop bits. Every bit lasts one period of an externally generated bit-rate tick. The tick is a single-cycle strobe, so the block runs at any rate the divider picks.

The buffer and the shift register report their state through separate flags. Software or a DMA engine can refill the buffer as soon as a character has moved into the shift register. Frames then follow each other with no idle gap. A single interrupt request pulses either when the buffer frees up or when a whole frame has left the line. The output can emulate an open-drain pin, in which case high levels are released instead of driven.

Top module: `cfg_uart_tx`

## Requirements
- R1: After reset, txd_o is 1, txd_oe_o is 1, buf_empty_o and sh_empty_o are 1, and irq_o is 0. Whenever sh_empty_o is 1, txd_o is 1.
- R2: mode_i sets the data length: 3'b100 gives 7 bits (wr_data_i[6:0]), 3'b101 gives 8 bits ([7:0]) and 3'b110 gives 9 bits ([8:0]). Buffer bits above the selected length do not affect the frame.
- R3: A frame is sent in this order: a start bit of 0, the data bits, the parity bit if enabled, then the stop bits of 1. The start bit appears in the cycle after the tick that loads the shift register. The line changes only in the cycle after a tick.
- R4: With msb_first_i=1 and mode 3'b101, the data bits go out from bit 7 down to bit 0. In every other case, including 7- and 9-bit modes with msb_first_i=1, bit 0 goes first.
- R5: With par_en_i=1, a parity bit follows the data. When par_odd_i=0, the data bits and the parity bit together hold an even number of ones. When par_odd_i=1, they hold an odd number of ones.
- R6: stop2_i=0 ends the frame with one stop bit, and stop2_i=1 ends it with two.
- R7: While tx_en_i=0, no new frame starts and the buffered character is kept. A frame already in progress still completes.
- R8: If mode_i is not one of the three legal codes, no frame starts and the buffer stays full.
- R9: On a tick where the shift register is idle or is ending its last stop bit, a full buffer moves into the shift register. buf_empty_o rises in the next cycle. sh_empty_o rises only after the last stop bit, and a waiting character follows with no idle bit.
- R10: With open_drain_i=1, txd_oe_o is 0 while the line is high and 1 while it is low. With open_drain_i=0, txd_oe_o is 1.
- R11: irq_o is a one-cycle pulse. With irq_sel_i=0 it comes in the same cycle that buf_empty_o rises. With irq_sel_i=1 it comes in the cycle after the tick that ends a frame's last stop bit.
- R12: A write while the buffer is full replaces the buffered character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Data length code |
| par_en_i | input | 1 | Add parity bit |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| stop2_i | input | 1 | 1 = two stop bits |
| msb_first_i | input | 1 | MSB-first order (8-bit mode only) |
| tx_en_i | input | 1 | Transmit enable |
| open_drain_i | input | 1 | Release the line instead of driving high |
| irq_sel_i | input | 1 | Interrupt source: 0 = buffer empty, 1 = frame complete |
| wr_i | input | 1 | Buffer write strobe |
| wr_data_i | input | 9 | Character to send |
| tick_i | input | 1 | One-cycle bit-rate strobe |
| txd_o | output | 1 | Serial line level |
| txd_oe_o | output | 1 | Output enable of the line |
| buf_empty_o | output | 1 | Holding buffer empty |
| sh_empty_o | output | 1 | Shift register empty, frame finished |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
A wrong bit counter or a stale shift register shows up on the line within one frame: the stop bit is missing or extra, a data bit is shifted, or a trailing start bit is never framed. A bench decoder that samples each bit at its tick catches all of these as a frame mismatch. Flag or interrupt logic that has drifted shows within one cycle of the load tick or the final tick, because buf_empty_o, sh_empty_o and irq_o must all move on exactly those edges. A load that starts while disabled or in an illegal mode appears as an unexpected start bit a single bit period later.

// File: rtl/cfg_uart_tx_pkg.sv
package cfg_uart_tx_pkg;
  localparam int DATA_MAX = 9;
  localparam int STOP_MAX = 2;
  localparam int REV_LEN  = 8;
  localparam int FRAME_W  = 1 + DATA_MAX + 1 + STOP_MAX;
  localparam int LEN_W    = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    MODE_7B = 3'b100,
    MODE_8B = 3'b101,
    MODE_9B = 3'b110
  } tx_mode_e;

  function automatic logic mode_ok(input logic [2:0] m);
    case (m)
      MODE_7B, MODE_8B, MODE_9B: mode_ok = 1'b1;
      default:                   mode_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] data_len(input logic [2:0] m);
    case (m)
      MODE_7B: data_len = LEN_W'(7);
      MODE_8B: data_len = LEN_W'(8);
      default: data_len = LEN_W'(DATA_MAX);
    endcase
  endfunction
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  // a write in the take cycle wins: the shifter got the old word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (wr_i) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/tx_frame_gen.sv
module tx_frame_gen
  import cfg_uart_tx_pkg::*;
#(
  parameter int DMAX = DATA_MAX,
  parameter int RLEN = REV_LEN,
  parameter int FW   = FRAME_W,
  parameter int LW   = LEN_W
) (
  input  logic [2:0]      mode_i,
  input  logic [DMAX-1:0] data_i,
  input  logic            par_en_i,
  input  logic            par_odd_i,
  input  logic            stop2_i,
  input  logic            msb_first_i,
  output logic [FW-1:0]   frame_o,
  output logic [LW-1:0]   len_o
);
  logic [LW-1:0]   dlen;
  logic [DMAX-1:0] masked;
  logic [DMAX-1:0] ordered;
  logic            rev_en;
  logic            par_bit;

  assign dlen   = LW'(data_len(mode_i));
  assign rev_en = msb_first_i && (mode_i == MODE_8B);

  always_comb begin
    for (int i = 0; i < DMAX; i++) begin
      masked[i] = (i < int'(dlen)) ? data_i[i] : 1'b0;
    end
  end

  for (genvar g = 0; g < DMAX; g++) begin : g_order
    if (g < RLEN) begin : g_rev
      assign ordered[g] = rev_en ? masked[RLEN-1-g] : masked[g];
    end else begin : g_fix
      assign ordered[g] = masked[g];
    end
  end

  assign par_bit = (^masked) ^ par_odd_i;

  // frame_o[0] goes out first; unused upper positions stay at stop level
  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DMAX; i++) begin
      if (i < int'(dlen)) frame_o[1+i] = ordered[i];
    end
    if (par_en_i) frame_o[int'(dlen)+1] = par_bit;
    len_o = dlen + LW'(1) + LW'(par_en_i) + (stop2_i ? LW'(STOP_MAX) : LW'(1));
  end
endmodule

// File: rtl/tx_shift_out.sv
module tx_shift_out #(
  parameter int FW = 13,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          tick_i,
  input  logic [FW-1:0] frame_i,
  input  logic [LW-1:0] len_i,
  output logic          line_o,
  output logic          busy_o,
  output logic          end_o
);
  logic [FW-1:0] sh_q;
  logic [LW-1:0] rem_q;
  logic          busy_q;
  logic          line_q;

  assign end_o = tick_i && busy_q && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      rem_q  <= '0;
      busy_q <= 1'b0;
      line_q <= 1'b1;
    end else if (load_i) begin
      line_q <= frame_i[0];
      sh_q   <= {1'b1, frame_i[FW-1:1]};
      rem_q  <= len_i - LW'(1);
      busy_q <= 1'b1;
    end else if (tick_i && busy_q) begin
      if (rem_q == '0) begin
        busy_q <= 1'b0;
        line_q <= 1'b1;
      end else begin
        line_q <= sh_q[0];
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        rem_q  <= rem_q - LW'(1);
      end
    end
  end

  assign line_o = line_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
  import cfg_uart_tx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          mode_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                stop2_i,
  input  logic                msb_first_i,
  input  logic                tx_en_i,
  input  logic                open_drain_i,
  input  logic                irq_sel_i,
  input  logic                wr_i,
  input  logic [DATA_MAX-1:0] wr_data_i,
  input  logic                tick_i,
  output logic                txd_o,
  output logic                txd_oe_o,
  output logic                buf_empty_o,
  output logic                sh_empty_o,
  output logic                irq_o
);
  logic                buf_full;
  logic [DATA_MAX-1:0] buf_data;
  logic [FRAME_W-1:0]  frame;
  logic [LEN_W-1:0]    frame_len;
  logic                line;
  logic                busy;
  logic                frame_end;
  logic                load;
  logic                irq_q;

  // reload on the final stop tick keeps frames back to back
  assign load = tick_i && tx_en_i && buf_full && mode_ok(mode_i) && (!busy || frame_end);

  tx_hold_buf #(.DATA_W(DATA_MAX)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (load),
    .full_o    (buf_full),
    .data_o    (buf_data)
  );

  tx_frame_gen #(
    .DMAX (DATA_MAX),
    .RLEN (REV_LEN),
    .FW   (FRAME_W),
    .LW   (LEN_W)
  ) u_gen (
    .mode_i      (mode_i),
    .data_i      (buf_data),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .stop2_i     (stop2_i),
    .msb_first_i (msb_first_i),
    .frame_o     (frame),
    .len_o       (frame_len)
  );

  tx_shift_out #(.FW(FRAME_W), .LW(LEN_W)) u_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .tick_i  (tick_i),
    .frame_i (frame),
    .len_i   (frame_len),
    .line_o  (line),
    .busy_o  (busy),
    .end_o   (frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_sel_i ? frame_end : (load && !wr_i);
  end

  assign txd_o       = line;
  assign txd_oe_o    = open_drain_i ? !line : 1'b1;
  assign buf_empty_o = !buf_full;
  assign sh_empty_o  = !busy;
  assign irq_o       = irq_q;
endmodule

// File: rtl/cfg_uart_tx_chk.sv
module cfg_uart_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       tx_en_i,
  input logic       wr_i,
  input logic       tick_i,
  input logic       txd_o,
  input logic       txd_oe_o,
  input logic       buf_empty_o,
  input logic       sh_empty_o,
  input logic       irq_o
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_empty_o |-> txd_o);

  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sh_empty_o) |-> !txd_o);

  assert_bit_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(txd_o));

  assert_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sh_empty_o) |-> ($past(tx_en_i) && $past(tick_i)));

  assert_legal_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sh_empty_o) |-> ($past(mode_i) == 3'b100 || $past(mode_i) == 3'b101 ||
                           $past(mode_i) == 3'b110));

  assert_move_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> !sh_empty_o);

  assert_low_driven_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_o |-> txd_oe_o);

  assert_irq_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_fill_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(buf_empty_o) |-> $past(wr_i));
endmodule

bind cfg_uart_tx cfg_uart_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .tx_en_i     (tx_en_i),
  .wr_i        (wr_i),
  .tick_i      (tick_i),
  .txd_o       (txd_o),
  .txd_oe_o    (txd_oe_o),
  .buf_empty_o (buf_empty_o),
  .sh_empty_o  (sh_empty_o),
  .irq_o       (irq_o)
);

// File: tb/cfg_uart_tx_bench.sv
module cfg_uart_tx_bench;
  localparam int FW   = 13;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b101;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, msb_first = 1'b0;
  logic       tx_en = 1'b1, open_drain = 1'b0, irq_sel = 1'b0;
  logic       wr = 1'b0;
  logic [8:0] wr_data = '0;
  logic       tick = 1'b0;
  logic       txd, txd_oe, buf_empty, sh_empty, irq;

  int n_chk = 0, n_fail = 0;
  int tcnt = 0;
  string cur_req = "R3";

  logic [FW-1:0] exp_q[$];
  int            exp_len_q[$];
  logic [FW-1:0] mon_v, mon_exp;
  int            mon_len = 0, mon_idx = 0;
  bit            mon_act = 1'b0;

  always #4 clk = ~clk;

  cfg_uart_tx u_cfg_uart_tx (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .par_en_i(par_en), .par_odd_i(par_odd),
    .stop2_i(stop2), .msb_first_i(msb_first), .tx_en_i(tx_en), .open_drain_i(open_drain),
    .irq_sel_i(irq_sel), .wr_i(wr), .wr_data_i(wr_data), .tick_i(tick),
    .txd_o(txd), .txd_oe_o(txd_oe), .buf_empty_o(buf_empty), .sh_empty_o(sh_empty),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [8:0] d, output logic [FW-1:0] f, output int n);
    int dl = (mode == 3'b100) ? 7 : (mode == 3'b101) ? 8 : 9;
    int ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < dl; i++) begin
      f[1+i] = (msb_first && dl == 8) ? d[7-i] : d[i];
      ones += int'(d[i]);
    end
    n = 1 + dl;
    if (par_en) begin
      f[n] = par_odd ? ~ones[0] : ones[0];
      n++;
    end
    n += stop2 ? 2 : 1;
  endtask

  // tick generator and line decoder share one process: the bit on the line
  // is sampled in the same half cycle its tick is raised
  always @(negedge clk) begin
    if (!rst_n) begin
      tcnt = 0;
      tick = 1'b0;
    end else begin
      tick = (tcnt == TDIV - 1);
      tcnt = (tcnt + 1) % TDIV;
      if (tick) begin
        if (!mon_act) begin
          if (txd == 1'b0) begin
            if (exp_q.size() == 0) begin
              chk(1'b0, "R7 R8 unexpected start", 32'd0, 32'd1);
            end else begin
              mon_exp = exp_q.pop_front();
              mon_len = exp_len_q.pop_front();
              mon_v   = '1;
              mon_v[0] = 1'b0;
              mon_idx = 1;
              mon_act = 1'b1;
            end
          end
        end else begin
          mon_v[mon_idx] = txd;
          mon_idx++;
          if (mon_idx == mon_len) begin
            chk(mon_v == mon_exp, cur_req, 32'(mon_v), 32'(mon_exp));
            mon_act = 1'b0;
          end
        end
      end
    end
  end

  task automatic wr_raw(input logic [8:0] d);
    @(negedge clk);
    wr = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic push_exp(input logic [8:0] d);
    logic [FW-1:0] f;
    int n;
    build(d, f, n);
    exp_q.push_back(f);
    exp_len_q.push_back(n);
  endtask

  task automatic send(input logic [8:0] d);
    push_exp(d);
    wr_raw(d);
  endtask

  task automatic wait_idle();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(buf_empty && sh_empty && !mon_act && exp_q.size() == 0) && k < 4000);
    chk(k < 4000, "R9 drain", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog R3 act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] d;
    bit         gap_seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", 32'(txd), 32'd1);
    chk(txd_oe == 1'b1, "R1 oe", 32'(txd_oe), 32'd1);
    chk(buf_empty == 1'b1, "R1 buf_empty", 32'(buf_empty), 32'd1);
    chk(sh_empty == 1'b1, "R1 sh_empty", 32'(sh_empty), 32'd1);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);

    // R2: lengths, upper bits set to prove they are ignored
    cur_req = "R2";
    mode = 3'b100; send(9'h1A5); wait_idle();
    mode = 3'b101; send(9'h15A); wait_idle();
    mode = 3'b110; send(9'h1C3); wait_idle();

    // R4: order only reversible at 8 bits
    cur_req = "R4";
    msb_first = 1'b1;
    mode = 3'b101; send(9'h013); wait_idle();
    mode = 3'b100; send(9'h013); wait_idle();
    mode = 3'b110; send(9'h113); wait_idle();
    msb_first = 1'b0;

    // R5: parity sense
    cur_req = "R5";
    mode = 3'b101; par_en = 1'b1;
    par_odd = 1'b0; send(9'h0B1); send(9'h0B0); wait_idle();
    par_odd = 1'b1; send(9'h0B1); send(9'h0B0); wait_idle();
    par_en = 1'b0;

    // R6: two stop bits
    cur_req = "R6";
    stop2 = 1'b1; send(9'h07E); send(9'h081); wait_idle();
    stop2 = 1'b0;

    // R9/R3: load timing, flags, back to back
    cur_req = "R9";
    send(9'h0F0);
    while (!buf_empty) @(negedge clk);
    chk(sh_empty == 1'b0, "R9 shifter busy after move", 32'(sh_empty), 32'd0);
    chk(txd == 1'b0, "R3 start bit right after load", 32'(txd), 32'd0);
    send(9'h00F);
    gap_seen = 1'b0;
    while (exp_q.size() != 0) begin
      @(negedge clk);
      if (sh_empty) gap_seen = 1'b1;
    end
    chk(!gap_seen, "R9 no gap between frames", 32'(gap_seen), 32'd0);
    wait_idle();

    // R7 + R12: disabled, overwrite, then enable
    cur_req = "R12";
    tx_en = 1'b0;
    wr_raw(9'h055);
    repeat (40) @(negedge clk);
    chk(sh_empty && txd, "R7 nothing sent while disabled", 32'({sh_empty, txd}), 32'd3);
    chk(!buf_empty, "R7 character kept", 32'(buf_empty), 32'd0);
    push_exp(9'h0AA);
    wr_raw(9'h0AA);
    tx_en = 1'b1;
    wait_idle();
    // R7: frame in progress completes after disable
    cur_req = "R7";
    send(9'h03C);
    while (sh_empty) @(negedge clk);
    tx_en = 1'b0;
    wait_idle();
    tx_en = 1'b1;

    // R8: illegal mode holds the buffer
    cur_req = "R8";
    mode = 3'b111;
    wr_raw(9'h099);
    repeat (40) @(negedge clk);
    chk(sh_empty && !buf_empty, "R8 no load in illegal mode", 32'({sh_empty, buf_empty}), 32'd2);
    mode = 3'b101;
    push_exp(9'h099);
    wait_idle();

    // R10: open drain
    cur_req = "R10";
    open_drain = 1'b1;
    @(negedge clk);
    chk(txd_oe == 1'b0, "R10 released when idle", 32'(txd_oe), 32'd0);
    send(9'h000);
    while (sh_empty) @(negedge clk);
    chk(txd_oe == 1'b1 && txd == 1'b0, "R10 low driven", 32'({txd_oe, txd}), 32'd2);
    wait_idle();
    chk(txd_oe == 1'b0, "R10 released after frame", 32'(txd_oe), 32'd0);
    open_drain = 1'b0;
    @(negedge clk);
    chk(txd_oe == 1'b1, "R10 push-pull drives", 32'(txd_oe), 32'd1);

    // R11: interrupt source
    cur_req = "R11";
    irq_sel = 1'b0;
    send(9'h0C5);
    while (!buf_empty) @(negedge clk);
    chk(irq == 1'b1, "R11 irq with buffer empty", 32'(irq), 32'd1);
    @(negedge clk);
    chk(irq == 1'b0, "R11 single cycle", 32'(irq), 32'd0);
    wait_idle();
    irq_sel = 1'b1;
    send(9'h05C);
    while (sh_empty) @(negedge clk);
    while (!sh_empty) begin
      @(negedge clk);
      if (!sh_empty) chk(irq == 1'b0, "R11 no early irq", 32'(irq), 32'd0);
    end
    chk(irq == 1'b1, "R11 irq at frame end", 32'(irq), 32'd1);
    wait_idle();
    irq_sel = 1'b0;

    // random frames (R3 framing across all options)
    cur_req = "R3";
    for (int k = 0; k < 40; k++) begin
      case ($urandom % 3)
        0:       mode = 3'b100;
        1:       mode = 3'b101;
        default: mode = 3'b110;
      endcase
      par_en    = 1'($urandom % 2);
      par_odd   = 1'($urandom % 2);
      stop2     = 1'($urandom % 2);
      msb_first = 1'($urandom % 2);
      d = 9'($urandom);
      send(d);
      if ($urandom % 2 == 1) begin
        while (!buf_empty) @(negedge clk);
        send(9'($urandom));
      end
      wait_idle();
    end

    chk(exp_q.size() == 0, "R3 all frames seen", 32'(exp_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule